// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-facing register file of an interrupt routing controller. A bus master reaches it through two directly addressed 32-bit locations. The first is an 8-bit selector. The second is a data window. The selector decides what the window reaches: a small identification register, a read-only capability word, an arbitration register that mirrors the identification value, or one half of a 64-bit routing entry. There is one routing entry per interrupt input pin.

Software first writes the selector and then reads or writes the window. The block keeps the selector, the 4-bit controller identifier and the routing table. The whole table is presented on a wide output bus for the pin delivery logic, which lies outside this block. Each routing entry holds:

- a vector in bits 7:0
- a delivery mode in bits 10:8
- a destination mode in bit 11
- a delivery status in bit 12
- a polarity in bit 13
- a remote-IRR flag in bit 14
- a trigger mode in bit 15
- a mask in bit 16
- a destination in bits 63:56

Accesses complete in one cycle. A read returns its data one clock after the request, marked by a one-cycle valid pulse.

Top module: `irq_route_regwin`

## Requirements
- R1: A write to offset 0x00 loads the selector from data bits 7:0, and the remaining data bits are dropped. A read of offset 0x00 returns the selector in bits 7:0 with zeros above.
- R2: A read request (valid high, write low) gives `acc_rvalid` high for exactly the following cycle, with its data on `acc_rdata`. A write request never raises `acc_rvalid`.
- R3: With selector 0x01, a window read returns NPINS-1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits zero. Window writes with this selector change nothing.
- R4: With selector 0x00, a window read returns the identifier in bits 27:24 and zeros elsewhere. A window write loads the identifier from data bits 27:24. Selector 0x02 reads the same word, and window writes with selector 0x02 change nothing.
- R5: A selector of 0x10 or above addresses table entry (selector-0x10)>>1. An even selector reaches entry bits 31:0 and an odd selector reaches entry bits 63:32.
- R6: A selector whose entry index is NPINS or more reads 0xFFFFFFFF, and so does any selector from 0x03 to 0x0F. Window writes with such a selector leave the table and the identifier unchanged.
- R7: A low-half write stores the data with bit 14 (remote IRR) forced to 0, whatever the data holds. A high-half write changes only entry bits 63:32.
- R8: After reset the selector is 0, the identifier is 0 and every entry reads 0x0000_0000_0001_0000, which is only the mask bit (bit 16) set.
- R9: A read of any offset other than 0x00 and 0x10 returns 0, and a write to such an offset has no effect.
- R10: `route_tbl` bits [64*i+63:64*i] always show entry i. A write is visible there from the cycle after the write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read request |
| acc_rdata | output | 32 | Read data |
| route_tbl | output | NPINS*64 | All routing entries, entry i at bits 64*i and up |

## Verification
Every table entry is mirrored on `route_tbl` straight from its register, so a wrong index decode, a misplaced half or a leaked remote-IRR bit shows there on the clock edge right after the write. The bench compares the full table against its own model on every cycle, and it also reads each half back through the window. Selector and identifier state is only visible through window reads. A corrupted selector therefore shows up on the next read, as the wrong register, a spurious all-ones word or a wrong capability word. Each window access is paired with reads that expose that state.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int SEL_W  = 8;
  localparam int DATA_W = 32;
  localparam int ENT_W  = 64;

  localparam logic [SEL_W-1:0] SEL_ID  = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL = 8'h10;

  localparam int RIRR_BIT = 14;

  typedef enum logic [1:0] {
    WK_ID   = 2'd0,
    WK_VER  = 2'd1,
    WK_TBL  = 2'd2,
    WK_ONES = 2'd3
  } win_kind_e;

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        level;
    logic        rirr;
    logic        pol;
    logic        busy;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } route_ent_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 8
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit_sel,
  output logic              hit_win,
  output logic              sel_wr,
  output logic              id_wr,
  output logic              tbl_wr_lo,
  output logic              tbl_wr_hi,
  output win_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] OFF_SEL = '0;
  localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);
  localparam logic [SEL_W-2:0]  NPINS_C = (SEL_W-1)'(NPINS);

  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] full_idx;
  logic             in_tbl;
  logic             wr;

  assign rel      = sel - SEL_TBL;
  assign full_idx = rel[SEL_W-1:1];
  assign in_tbl   = (sel >= SEL_TBL) && (full_idx < NPINS_C);
  assign idx      = in_tbl ? full_idx[IDX_W-1:0] : '0;

  always_comb begin
    if (sel == SEL_ID || sel == SEL_ARB) kind = WK_ID;
    else if (sel == SEL_VER)             kind = WK_VER;
    else if (in_tbl)                     kind = WK_TBL;
    else                                 kind = WK_ONES;
  end

  assign hit_sel   = (acc_offset == OFF_SEL);
  assign hit_win   = (acc_offset == OFF_WIN);
  assign wr        = acc_valid && acc_write;
  assign sel_wr    = wr && hit_sel;
  assign id_wr     = wr && hit_win && (sel == SEL_ID);
  assign tbl_wr_lo = wr && hit_win && (kind == WK_TBL) && !rel[0];
  assign tbl_wr_hi = wr && hit_win && (kind == WK_TBL) &&  rel[0];
endmodule

// File: rtl/regwin_table.sv
module regwin_table
  import regwin_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_lo,
  input  logic                   wr_hi,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NPINS*ENT_W-1:0] tbl_flat
);
  localparam route_ent_t        RST_ENT = '{mask: 1'b1, default: '0};
  localparam logic [DATA_W-1:0] LO_KEEP = ~(DATA_W'(1) << RIRR_BIT);

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    logic             hit;
    assign hit = (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= RST_ENT;
      end else begin
        if (wr_lo && hit) ent_q[DATA_W-1:0]     <= wdata & LO_KEEP;
        if (wr_hi && hit) ent_q[ENT_W-1:DATA_W] <= wdata;
      end
    end

    assign tbl_flat[g*ENT_W +: ENT_W] = ent_q;
  end
endmodule

// File: rtl/regwin_readmux.sv
module regwin_readmux
  import regwin_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         IDX_W   = 5,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                   hit_sel,
  input  logic                   hit_win,
  input  logic [SEL_W-1:0]       sel,
  input  logic [3:0]             id,
  input  win_kind_e              kind,
  input  logic [IDX_W-1:0]       idx,
  input  logic [NPINS*ENT_W-1:0] tbl_flat,
  output logic [DATA_W-1:0]      rdata
);
  localparam logic [DATA_W-1:0] VER_WORD = {8'h00, 8'(NPINS-1), 8'h00, VERSION};

  logic [ENT_W-1:0]  entry;
  logic [DATA_W-1:0] half;

  assign entry = tbl_flat[int'(idx)*ENT_W +: ENT_W];
  assign half  = sel[0] ? entry[ENT_W-1:DATA_W] : entry[DATA_W-1:0];

  always_comb begin
    rdata = '0;
    if (hit_sel) begin
      rdata = {{(DATA_W-SEL_W){1'b0}}, sel};
    end else if (hit_win) begin
      case (kind)
        WK_ID:   rdata = {4'h0, id, 24'h0};
        WK_VER:  rdata = VER_WORD;
        WK_TBL:  rdata = half;
        default: rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import regwin_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ADDR_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_offset,
  input  logic [DATA_W-1:0]      acc_wdata,
  output logic                   acc_rvalid,
  output logic [DATA_W-1:0]      acc_rdata,
  output logic [NPINS*ENT_W-1:0] route_tbl
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [SEL_W-1:0]  sel_q;
  logic [3:0]        id_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_nxt;

  logic             hit_sel, hit_win, sel_wr, id_wr, tbl_wr_lo, tbl_wr_hi;
  win_kind_e        kind;
  logic [IDX_W-1:0] idx;

  regwin_decode #(.NPINS(NPINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_offset(acc_offset),
    .sel       (sel_q),
    .hit_sel   (hit_sel),
    .hit_win   (hit_win),
    .sel_wr    (sel_wr),
    .id_wr     (id_wr),
    .tbl_wr_lo (tbl_wr_lo),
    .tbl_wr_hi (tbl_wr_hi),
    .kind      (kind),
    .idx       (idx)
  );

  regwin_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (tbl_wr_lo),
    .wr_hi   (tbl_wr_hi),
    .idx     (idx),
    .wdata   (acc_wdata),
    .tbl_flat(route_tbl)
  );

  regwin_readmux #(.NPINS(NPINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rmux (
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .sel     (sel_q),
    .id      (id_q),
    .kind    (kind),
    .idx     (idx),
    .tbl_flat(route_tbl),
    .rdata   (rdata_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      id_q     <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= acc_wdata[SEL_W-1:0];
      if (id_wr)  id_q  <= acc_wdata[27:24];
      rvalid_q <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rdata_q <= rdata_nxt;
    end
  end

  assign acc_rvalid = rvalid_q;
  assign acc_rdata  = rdata_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         ADDR_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_write,
  input logic [ADDR_W-1:0]   acc_offset,
  input logic [31:0]         acc_wdata,
  input logic                acc_rvalid,
  input logic [31:0]         acc_rdata,
  input logic [NPINS*64-1:0] route_tbl,
  input logic [7:0]          sel_q
);
  localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);
  localparam logic [7:0]        NP8     = 8'(NPINS);

  logic rd_req, wr_req, oor_sel;
  assign rd_req  = acc_valid && !acc_write;
  assign wr_req  = acc_valid && acc_write;
  assign oor_sel = (sel_q >= 8'h03) &&
                   ((sel_q < 8'h10) || (((sel_q - 8'h10) >> 1) >= NP8));

  // R1
  sel_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req && acc_offset == '0 |=> sel_q == $past(acc_wdata[7:0]));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> acc_rvalid);

  // R2
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !acc_rvalid);

  // R3
  ver_word_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && acc_offset == OFF_WIN && sel_q == 8'h01
    |=> acc_rdata == {8'h00, 8'(NPINS-1), 8'h00, VERSION});

  // R6
  oor_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && acc_offset == OFF_WIN && oor_sel |=> acc_rdata == 32'hFFFF_FFFF);

  // R6
  oor_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req && acc_offset == OFF_WIN && oor_sel |=> $stable(route_tbl));

  // R9
  other_off_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && acc_offset != '0 && acc_offset != OFF_WIN |=> acc_rdata == 32'h0);

  // R8
  rst_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sel_q == 8'h00 && !acc_rvalid);

  for (genvar g = 0; g < NPINS; g++) begin : g_rirr
    // R7
    rirr_clear_chk: assert property (@(posedge clk) disable iff (rst)
      route_tbl[g*64+14] == 1'b0);
  end
endmodule

bind irq_route_regwin regwin_chk #(.NPINS(NPINS), .VERSION(VERSION), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_offset(acc_offset),
  .acc_wdata (acc_wdata),
  .acc_rvalid(acc_rvalid),
  .acc_rdata (acc_rdata),
  .route_tbl (route_tbl),
  .sel_q     (sel_q)
);

// File: tb/irq_route_regwin_test.sv
module irq_route_regwin_test;
  localparam int         NPINS = 24;
  localparam logic [7:0] VER   = 8'h11;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 acc_valid = 1'b0;
  logic                 acc_write = 1'b0;
  logic [7:0]           acc_offset = '0;
  logic [31:0]          acc_wdata = '0;
  logic                 acc_rvalid;
  logic [31:0]          acc_rdata;
  logic [NPINS*64-1:0]  route_tbl;

  always #5 clk = ~clk;

  irq_route_regwin #(.NPINS(NPINS), .VERSION(VER), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rvalid(acc_rvalid),
    .acc_rdata(acc_rdata), .route_tbl(route_tbl)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_tbl [NPINS];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic        exp_rv = 1'b0;
  logic [31:0] exp_rd = '0;
  string       exp_tag = "R8";

  function automatic int m_index();
    if (m_sel < 8'h10) return -1;
    if (((int'(m_sel) - 16) >> 1) >= NPINS) return -1;
    return (int'(m_sel) - 16) >> 1;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] off);
    int ix;
    if (off == 8'h00) return {24'h0, m_sel};
    if (off != 8'h10) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(NPINS-1), 8'h00, VER};
    ix = m_index();
    if (ix < 0) return 32'hFFFF_FFFF;
    return m_sel[0] ? m_tbl[ix][63:32] : m_tbl[ix][31:0];
  endfunction

  task automatic m_write(logic [7:0] off, logic [31:0] d);
    int ix;
    if (off == 8'h00) m_sel = d[7:0];
    else if (off == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[27:24];
      else begin
        ix = m_index();
        if (ix >= 0) begin
          if (m_sel[0]) m_tbl[ix][63:32] = d;
          else begin
            m_tbl[ix][31:0] = d;
            m_tbl[ix][14]   = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    int bad_pin;
    check({exp_tag, "/R2 rvalid"}, 64'(acc_rvalid), 64'(exp_rv));
    if (exp_rv) check(exp_tag, 64'(acc_rdata), 64'(exp_rd));
    bad_pin = -1;
    for (int p = 0; p < NPINS; p++)
      if (bad_pin < 0 && route_tbl[p*64 +: 64] !== m_tbl[p]) bad_pin = p;
    if (bad_pin < 0) check("R10 table", 64'h0, 64'h0);
    else check($sformatf("R10 table pin %0d", bad_pin),
               route_tbl[bad_pin*64 +: 64], m_tbl[bad_pin]);
  endtask

  task automatic step(logic v, logic w, logic [7:0] off, logic [31:0] d, string tag);
    @(negedge clk);
    compare_all();
    acc_valid  = v;
    acc_write  = w;
    acc_offset = off;
    acc_wdata  = d;
    exp_rv     = v && !w;
    exp_tag    = tag;
    if (exp_rv) exp_rd = m_read(off);
    if (v && w) m_write(off, d);
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] d, string tag);
    step(1'b1, 1'b1, off, d, tag);
  endtask

  task automatic rd(logic [7:0] off, string tag);
    step(1'b1, 1'b0, off, 32'h0, tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    m_sel = '0;
    m_id  = '0;
    for (int p = 0; p < NPINS; p++) m_tbl[p] = 64'h0000_0000_0001_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    rd(8'h00, "R8 select");
    rd(8'h10, "R8 id");
    wr(8'h00, 32'h10, "R8");
    rd(8'h10, "R8 pin0 lo");
    wr(8'h00, 32'h11, "R8");
    rd(8'h10, "R8 pin0 hi");
    wr(8'h00, 8'(16 + 2*(NPINS-1)), "R8");
    rd(8'h10, "R8 last lo");

    // R1 select keeps low byte
    wr(8'h00, 32'h1234_56A5, "R1");
    rd(8'h00, "R1 select");
    step(1'b0, 1'b0, 8'h00, 32'h0, "R2 idle");

    // R3 capability word, writes ignored
    wr(8'h00, 32'h01, "R3");
    rd(8'h10, "R3 version");
    wr(8'h10, 32'hFFFF_FFFF, "R3");
    rd(8'h10, "R3 after write");

    // R4 identifier and arbitration mirror
    wr(8'h00, 32'h00, "R4");
    wr(8'h10, 32'hF5AB_CDEF, "R4");
    rd(8'h10, "R4 id");
    wr(8'h00, 32'h02, "R4");
    rd(8'h10, "R4 arb");
    wr(8'h10, 32'h0A00_0000, "R4");
    rd(8'h10, "R4 arb after write");
    wr(8'h00, 32'h00, "R4");
    rd(8'h10, "R4 id kept");

    // R5 R7 every entry, both halves
    for (int p = 0; p < NPINS; p++) begin
      wr(8'h00, 32'(16 + 2*p), "R5");
      wr(8'h10, 32'hFFFF_FFFF ^ (32'(p) << 3), "R7 lo");
      wr(8'h00, 32'(17 + 2*p), "R5");
      wr(8'h10, 32'h5A5A_5A5A ^ {8'(p), 24'h0}, "R7 hi");
      rd(8'h10, "R5 hi read");
      wr(8'h00, 32'(16 + 2*p), "R5");
      rd(8'h10, "R7 lo read");
    end
    // R7 high write leaves low half, low write clears remote IRR again
    wr(8'h00, 32'h13, "R7");
    wr(8'h10, 32'h0000_0000, "R7 hi only");
    wr(8'h00, 32'h12, "R7");
    rd(8'h10, "R7 lo intact");
    wr(8'h10, 32'h0000_4000, "R7 rirr");
    rd(8'h10, "R7 rirr read");

    // R6 out of range selects
    wr(8'h00, 8'(16 + 2*NPINS), "R6");
    rd(8'h10, "R6 first oor");
    wr(8'h10, 32'h0, "R6 write dropped");
    wr(8'h00, 8'(17 + 2*NPINS), "R6");
    wr(8'h10, 32'h0, "R6 write dropped hi");
    rd(8'h10, "R6 oor hi");
    wr(8'h00, 32'h05, "R6");
    rd(8'h10, "R6 gap select");
    wr(8'h10, 32'h0F00_0000, "R6 gap write");
    wr(8'h00, 32'hFF, "R6");
    rd(8'h10, "R6 ff");
    wr(8'h00, 32'h00, "R6");
    rd(8'h10, "R6 id unchanged");

    // R9 other offsets
    rd(8'h20, "R9 off20");
    wr(8'h04, 32'hFFFF_FFFF, "R9");
    wr(8'h20, 32'hFFFF_FFFF, "R9");
    rd(8'hF0, "R9 offF0");
    rd(8'h00, "R9 select unchanged");
    rd(8'h10, "R9 id unchanged");

    step(1'b0, 1'b0, 8'h00, 32'h0, "R2 idle");
    step(1'b0, 1'b0, 8'h00, 32'h0, "R2 idle");
    finish_run();
  end
endmodule